// File: doc/BRIEF.md
# Debug Bus Region Decoder

This block is a memory-mapped slave sitting between a system bus and a processor's debug port. Each single-beat read or write request carries a 17-bit byte offset into the debug window. The offset is split into four 32 KB regions: control/status registers, the general register file, run-control registers, and a region served by the block itself. Every register is 64 bits wide, so the register index within a region is the in-region offset divided by eight.

Accesses to the first three regions are forwarded to the processor's debug-port request/response interface. The block raises a request carrying the region code, the index, a write flag and the write data. It holds that request until the port acknowledges, and only then answers on the bus. Accesses to the fourth region are served by a small register file inside the block and never reach the debug port. A write to the read-only current-instruction-pointer entry is completed on the bus but is not forwarded.

Only one transaction is in flight at a time. A new request is not accepted until the previous response has been taken.

Top module: `dbg_region_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `dp_valid` are 0.
- R2: Offset bits [16:15] select the region, and `dp_region` carries this code on forwarded accesses: 0 for control/status registers (0x00000–0x07FFF), 1 for general registers (0x08000–0x0FFFF), 2 for run control (0x10000–0x17FFF), 3 for local (0x18000–0x1FFFF).
- R3: `dp_index` equals offset bits [14:3], and offset bits [2:0] are ignored. For example, offset 0x03C10 gives index 0x782.
- R4: On a forwarded access, `dp_valid` stays high with stable region, index, write flag and write data until the cycle in which `dp_ready` is 1. The bus response follows on the next cycle, with `rsp_rdata` equal to the `dp_rdata` sampled in that acknowledge cycle.
- R5: `dp_write` equals the request's write flag, and `dp_wdata` equals the request's write data.
- R6: In region 1, index 32 is the current instruction pointer and index 33 is the next instruction pointer. Reads of either are forwarded, as are writes to index 33. A write to index 32 (offset 0x08100) issues no debug-port request and completes with `rsp_rdata` = 0.
- R7: Accesses to region 3 never raise `dp_valid`. Local indices 0 to LOCAL_REGS-1 (default 4) are 64-bit registers, reset to 0, that return the last value written.
- R8: In region 3, a read of an index at or above LOCAL_REGS returns 0. A write to such an index changes no local register, including any register whose index shares its low bits.
- R9: `req_ready` is 0 from the accepting edge until the response is taken. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_rdata` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte offset inside the debug window |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Bus takes the response |
| rsp_rdata | output | 64 | Read data (0 for local writes and dropped writes) |
| dp_valid | output | 1 | Debug-port request |
| dp_ready | input | 1 | Debug-port acknowledge |
| dp_region | output | 2 | Region code of the request |
| dp_index | output | 12 | Register index within the region |
| dp_write | output | 1 | Request is a write |
| dp_wdata | output | 64 | Write data to the port |
| dp_rdata | input | 64 | Read data from the port, valid with `dp_ready` |

## Verification
The assertions assume that the debug port only raises `dp_ready` while `dp_valid` is high. They also assume the bus holds `rsp_ready` low or high without regard to protocol violations of its own. The bench's port responder keeps to this rule: it acknowledges only a request it sees pending, after a latency chosen per access, and drops `dp_ready` once `dp_valid` falls. On the bus side the bench presents one request at a time. It asserts `rsp_ready` only after it has seen `rsp_valid`, and during the back-pressure test it deliberately holds `rsp_ready` low for several cycles.

// File: rtl/dbg_bridge_pkg.sv
// Shared types for the debug bus region decoder.
// Region codes are decoded from the top offset bits, so their values are fixed.
package dbg_bridge_pkg;
    typedef enum logic [1:0] {
        RGN_CSR   = 2'd0,
        RGN_GPR   = 2'd1,
        RGN_RUN   = 2'd2,
        RGN_LOCAL = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PORT = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    // General-register index of the read-only current instruction pointer
    localparam int unsigned PC_INDEX = 32;
endpackage

// File: rtl/dbg_region_decode.sv
// Offset decoder: splits a byte offset into a region code and a register index.
// It also flags accesses that must not reach the debug port.
// Assumes 64-bit registers, so the low three offset bits are ignored.
module dbg_region_decode
    import dbg_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned REG_LOG2 = 3,
    localparam int unsigned IDX_W   = ADDR_W - 2 - REG_LOG2
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic              write,
    output region_e           region,
    output logic [IDX_W-1:0]  index,
    output logic              is_local,
    output logic              is_dropped
);
    logic unused_low;

    // Region is the top two offset bits; index is the in-region offset over the register size
    always_comb begin
        region     = region_e'(offset[ADDR_W-1 -: 2]);
        index      = offset[ADDR_W-3 : REG_LOG2];
        is_local   = (region == RGN_LOCAL);
        is_dropped = write && (region == RGN_GPR) && (index == IDX_W'(PC_INDEX));
    end

    assign unused_low = ^offset[REG_LOG2-1:0];
endmodule

// File: rtl/dbg_local_regs.sv
// Local register file for the region served inside the block.
// Indices at or above NUM_REGS read as zero and ignore writes.
// Assumes NUM_REGS is at least 1 and fits in the index width.
module dbg_local_regs #(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned IDX_W    = 12,
    parameter int unsigned NUM_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Full-index compare so out-of-range writes never alias a register
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                regs_q[g] <= wr_data;
        end
    end

    // Read mux: zero unless the index names an implemented register
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IDX_W'(i))
                rd_data = regs_q[i];
    end
endmodule

// File: rtl/dbg_txn_ctrl.sv
// Transaction controller: accepts one request, forwards or serves it, then
// holds the response until taken. Assumes the debug port only acknowledges
// a pending request.
module dbg_txn_ctrl
    import dbg_bridge_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  region_e           dec_region,
    input  logic [IDX_W-1:0]  dec_index,
    input  logic              dec_local,
    input  logic              dec_dropped,
    input  logic [DATA_W-1:0] local_rdata,
    output logic              local_we,
    output logic              dp_valid,
    input  logic              dp_ready,
    output logic [1:0]        dp_region,
    output logic [IDX_W-1:0]  dp_index,
    output logic              dp_write,
    output logic [DATA_W-1:0] dp_wdata,
    input  logic [DATA_W-1:0] dp_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata
);
    state_e            state_q;
    logic [1:0]        rgn_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept;

    // Handshake decode for the bus side
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
        local_we  = accept && dec_local && req_write;
    end

    // One-transaction state machine with captured request and response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rgn_q   <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    rgn_q   <= dec_region;
                    idx_q   <= dec_index;
                    wr_q    <= req_write;
                    wdata_q <= req_wdata;
                    if (dec_local || dec_dropped) begin
                        rdata_q <= (dec_local && !req_write) ? local_rdata : '0;
                        state_q <= ST_RESP;
                    end else begin
                        state_q <= ST_PORT;
                    end
                end
                ST_PORT: if (dp_ready) begin
                    rdata_q <= dp_rdata;
                    state_q <= ST_RESP;
                end
                ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output view of the captured transaction
    always_comb begin
        dp_valid  = (state_q == ST_PORT);
        dp_region = rgn_q;
        dp_index  = idx_q;
        dp_write  = wr_q;
        dp_wdata  = wdata_q;
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rdata_q;
    end
endmodule

// File: rtl/dbg_region_bridge.sv
// Debug bus region decoder top: bus slave to debug-port bridge with a local
// register region. One transaction outstanding; synchronous active-low reset.
module dbg_region_bridge
    import dbg_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W     = 17,
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned REG_LOG2   = 3,
    parameter int unsigned LOCAL_REGS = 4,
    localparam int unsigned IDX_W     = ADDR_W - 2 - REG_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dp_valid,
    input  logic              dp_ready,
    output logic [1:0]        dp_region,
    output logic [IDX_W-1:0]  dp_index,
    output logic              dp_write,
    output logic [DATA_W-1:0] dp_wdata,
    input  logic [DATA_W-1:0] dp_rdata
);
    region_e           dec_region;
    logic [IDX_W-1:0]  dec_index;
    logic              dec_local;
    logic              dec_dropped;
    logic              local_we;
    logic [DATA_W-1:0] local_rdata;

    dbg_region_decode #(.ADDR_W(ADDR_W), .REG_LOG2(REG_LOG2)) i_decode (
        .offset     (req_addr),
        .write      (req_write),
        .region     (dec_region),
        .index      (dec_index),
        .is_local   (dec_local),
        .is_dropped (dec_dropped)
    );

    dbg_local_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(LOCAL_REGS)) i_local (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (local_we),
        .wr_idx  (dec_index),
        .wr_data (req_wdata),
        .rd_idx  (dec_index),
        .rd_data (local_rdata)
    );

    dbg_txn_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .dec_region  (dec_region),
        .dec_index   (dec_index),
        .dec_local   (dec_local),
        .dec_dropped (dec_dropped),
        .local_rdata (local_rdata),
        .local_we    (local_we),
        .dp_valid    (dp_valid),
        .dp_ready    (dp_ready),
        .dp_region   (dp_region),
        .dp_index    (dp_index),
        .dp_write    (dp_write),
        .dp_wdata    (dp_wdata),
        .dp_rdata    (dp_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_rdata   (rsp_rdata)
    );
endmodule

// File: rtl/dbg_region_bridge_chk.sv
// Protocol checker for the debug bus region decoder, bound to the top module.
// Assumes the debug port acknowledges only while a request is pending.
module dbg_region_bridge_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              dp_valid,
    input logic              dp_ready,
    input logic [1:0]        dp_region,
    input logic [IDX_W-1:0]  dp_index,
    input logic              dp_write,
    input logic [DATA_W-1:0] dp_wdata
);
    // R4: a pending request keeps its fields until acknowledged
    a_r4_dp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid && !dp_ready |=> dp_valid && $stable(dp_region) && $stable(dp_index)
                                  && $stable(dp_write) && $stable(dp_wdata));

    // R4: an acknowledged request is followed by the response
    a_r4_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid && dp_ready |=> rsp_valid && !dp_valid);

    // R7: the local region never reaches the debug port
    a_r7_no_local_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid |-> dp_region != 2'd3);

    // R6: the current instruction pointer is never written through the port
    a_r6_pc_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid && dp_region == 2'd1 && dp_index == IDX_W'(32) |-> !dp_write);

    // R9: no new request while a response is pending
    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || dp_valid) |-> !req_ready);

    // R9: a stalled response holds its data
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
endmodule

bind dbg_region_bridge dbg_region_bridge_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_dbg_region_bridge.sv
// Bench for the debug bus region decoder: vector table walk, then directed tests.
module test_dbg_region_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_rdata;
    logic        dp_valid;
    logic        dp_ready = 1'b0;
    logic [1:0]  dp_region;
    logic [11:0] dp_index;
    logic        dp_write;
    logic [63:0] dp_wdata;
    logic [63:0] dp_rdata = '0;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dbg_region_bridge i_dbg_region_bridge (.*);

    function automatic logic [63:0] port_data(input logic [1:0] r, input logic [11:0] i);
        return 64'hD500_0000_0000_0000 | (64'(r) << 32) | 64'(i);
    endfunction

    // Debug-port responder: acknowledges after resp_lat waiting cycles
    int          resp_lat = 0;
    int          wait_cnt = 0;
    int          dp_reqs = 0;
    logic [1:0]  last_rgn;
    logic [11:0] last_idx;
    logic        last_wr;
    logic [63:0] last_wdata;
    always @(negedge clk) begin
        if (dp_valid && !dp_ready) begin
            if (wait_cnt >= resp_lat) begin
                dp_ready   <= 1'b1;
                dp_rdata   <= port_data(dp_region, dp_index);
                last_rgn   <= dp_region;
                last_idx   <= dp_index;
                last_wr    <= dp_write;
                last_wdata <= dp_wdata;
                dp_reqs    <= dp_reqs + 1;
                wait_cnt   <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            dp_ready <= 1'b0;
            wait_cnt <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One bus access; returns read data and the number of cycles dp_valid was seen
    task automatic access(input logic w, input logic [16:0] a, input logic [63:0] d,
                          output logic [63:0] rd, output int dpc);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        dpc = 0;
        while (!rsp_valid) begin
            if (dp_valid) dpc++;
            @(negedge clk);
        end
        rd = rsp_rdata;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    localparam int N = 9;
    localparam logic        V_WR   [N] = '{0, 0, 1, 0, 0, 1, 0, 0, 0};
    localparam logic [16:0] V_ADDR [N] = '{17'h03C10, 17'h03C17, 17'h08008, 17'h08108,
                                          17'h08100, 17'h08108, 17'h10008, 17'h07FF8, 17'h0FFF8};
    localparam logic [63:0] V_WD   [N] = '{64'h0, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h0,
                                          64'h0, 64'hCAFE_0000_0000_0042, 64'h0, 64'h0, 64'h0};
    localparam int          V_LAT  [N] = '{0, 2, 1, 3, 0, 0, 5, 1, 0};
    localparam logic [1:0]  V_RGN  [N] = '{0, 0, 1, 1, 1, 1, 2, 0, 1};
    localparam logic [11:0] V_IDX  [N] = '{12'h782, 12'h782, 12'd1, 12'd33, 12'd32,
                                          12'd33, 12'd1, 12'hFFF, 12'hFFF};

    initial begin
        logic [63:0] rd;
        logic [63:0] held;
        int dpc;
        int reqs0;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready === 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
        check(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check(dp_valid === 1'b0, "R1", "dp_valid in reset", 64'(dp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);

        // Vector walk: forwarded accesses in regions 0..2 (R2 R3 R4 R5 R6)
        for (int k = 0; k < N; k++) begin
            resp_lat = V_LAT[k];
            reqs0 = dp_reqs;
            access(V_WR[k], V_ADDR[k], V_WD[k], rd, dpc);
            check(dp_reqs == reqs0 + 1, "R2", "one port request", 64'(dp_reqs - reqs0), 64'd1);
            check(last_rgn == V_RGN[k], "R2", "region code", 64'(last_rgn), 64'(V_RGN[k]));
            check(last_idx == V_IDX[k], "R3", "register index", 64'(last_idx), 64'(V_IDX[k]));
            check(dpc == V_LAT[k] + 1, "R4", "request held until ack", 64'(dpc), 64'(V_LAT[k] + 1));
            check(last_wr == V_WR[k], "R5", "write flag", 64'(last_wr), 64'(V_WR[k]));
            if (V_WR[k])
                check(last_wdata == V_WD[k], "R5", "write data", last_wdata, V_WD[k]);
            else
                check(rd == port_data(V_RGN[k], V_IDX[k]), "R4", "read data",
                      rd, port_data(V_RGN[k], V_IDX[k]));
        end

        // R6: write to the current instruction pointer is dropped
        reqs0 = dp_reqs;
        access(1'b1, 17'h08100, 64'hFFFF_0000_FFFF_0000, rd, dpc);
        check(dp_reqs == reqs0 && dpc == 0, "R6", "no port request on pc write",
              64'(dp_reqs - reqs0), 64'd0);
        check(rd == 64'd0, "R6", "pc write response data", rd, 64'd0);

        // R7: local region write/read without port traffic
        reqs0 = dp_reqs;
        access(1'b1, 17'h18008, 64'hA5A5_0001_0002_0003, rd, dpc);
        access(1'b1, 17'h18000, 64'h0000_1111_2222_3333, rd, dpc);
        access(1'b0, 17'h18008, 64'h0, rd, dpc);
        check(rd == 64'hA5A5_0001_0002_0003, "R7", "local reg 1 readback", rd, 64'hA5A5_0001_0002_0003);
        access(1'b0, 17'h18018, 64'h0, rd, dpc);
        check(rd == 64'd0, "R7", "local reg 3 reset value", rd, 64'd0);

        // R8: out-of-range local index reads zero and does not alias
        access(1'b1, 17'h18400, 64'hDEAD_BEEF_DEAD_BEEF, rd, dpc);
        access(1'b0, 17'h18400, 64'h0, rd, dpc);
        check(rd == 64'd0, "R8", "unimplemented local index reads zero", rd, 64'd0);
        access(1'b0, 17'h18000, 64'h0, rd, dpc);
        check(rd == 64'h0000_1111_2222_3333, "R8", "local reg 0 untouched", rd, 64'h0000_1111_2222_3333);
        check(dp_reqs == reqs0, "R7", "no port requests for local region", 64'(dp_reqs - reqs0), 64'd0);

        // R9: response back-pressure and single outstanding request
        resp_lat = 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h10010;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        held = rsp_rdata;
        repeat (3) begin
            @(negedge clk);
            check(rsp_valid === 1'b1 && rsp_rdata == held, "R9", "response held",
                  rsp_rdata, held);
            check(req_ready === 1'b0, "R9", "no accept while response pending",
                  64'(req_ready), 64'd0);
        end
        check(held == port_data(2'd2, 12'd2), "R4", "stalled read data", held, port_data(2'd2, 12'd2));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(rsp_valid === 1'b0 && req_ready === 1'b1, "R9", "idle after response taken",
              64'({rsp_valid, req_ready}), 64'b01);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule